// File: doc/BRIEF.md
# Programmable Down-Counter Timer

This block is a memory-mapped timer. Software programs it over a simple single-cycle register bus, with select, enable, write strobe, byte address and 32-bit data. It raises one level interrupt when the count reaches zero. A single clock runs both the bus and the counter. A separate tick-enable input marks the clock cycles that count as timer clock edges. A prescaler divides those enabled edges by 1, 16 or 256 to form the counting ticks.

The count decrements once per counting tick while the timer is enabled. At zero it does one of three things: it reloads (periodic), it stops (one-shot), or it wraps to all ones for the chosen width (free-running). Two write paths reach the reload value. A direct load also restarts the count at the next counting tick. A background load only changes the value used at the next reload. A read of the load register always returns the reload value that is pending.

Top module: `dtm_timer`

## Requirements
- R1: After reset, every readable register reads zero and `irq` is low.
- R2: The register map uses byte offsets. Control is at 0x00, load at 0x04, current value at 0x08, raw status at 0x0C, masked status at 0x10, clear at 0x14 and background load at 0x18. The control bits are: bit7 enable, bit6 periodic, bit5 interrupt enable, bits[3:2] prescale, bit1 32-bit size, bit0 one-shot. Control bit 4 always reads 0.
- R3: A write to load (0x04) sets the reload value. It also replaces the count at the next counting tick, and that tick does not decrement. A read of 0x04 then returns the written value.
- R4: A write to background load (0x18) changes only the reload value. The count keeps decrementing, and a read of 0x04 returns the new value.
- R5: If load and then background load are written before a counting tick, that tick loads the load value. Later reloads use the background value.
- R6: With periodic set and one-shot clear, a tick at count 0 reloads the reload value. A reload value N therefore gives a period of N+1 ticks.
- R7: With one-shot set, a count at 0 stays at 0 on later ticks until a load-register write restarts it. One-shot takes priority over periodic.
- R8: When both one-shot and periodic are clear, a tick at 0 wraps the count to 0xFFFFFFFF, or to 0xFFFF when the size bit is 0. With the size bit at 0, only bits [15:0] of the count and of loaded values are used.
- R9: A counting tick occurs on every 1st, 16th or 256th enabled clock edge for prescale codes 0, 1 and 2. Code 3 acts as divide-by-1. There are no ticks while enable is 0, and a control write restarts the prescale phase.
- R10: Raw status (bit 0 of 0x0C) sets when a tick decrements the count from 1 to 0. Any write to 0x14, whatever the data, clears it.
- R11: Masked status (bit 0 of 0x10) and `irq` equal raw status ANDed with the interrupt enable.
- R12: If a zero event and a clear write fall in the same cycle, raw status stays set.
- R13: Writes to 0x08, 0x0C, 0x10 and unmapped offsets change nothing. Reads of 0x14 and unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bus and the counter |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Marks a clock cycle as an enabled timer clock edge |
| psel | input | 1 | Register select |
| penable | input | 1 | Access phase; a transfer takes place when psel and penable are both high |
| pwrite | input | 1 | 1 for a write, 0 for a read |
| paddr | input | 5 | Byte offset of the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, combinational from paddr |
| irq | output | 1 | Masked interrupt |

## Verification
The hardest case to reach is the collision between a clear write and a zero event in the same cycle. The bench reaches it by holding tick_en low between accesses, so the count freezes at 1 with raw status already set. It then issues the clear write in the one cycle where it raises tick_en. The load/background race and the divide-by-256 boundary are set up the same way: tick_en is counted out one enabled edge at a time, so the exact tick on which a value lands can be read back.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

  localparam int CNT_W    = 32;
  localparam int NARROW_W = 16;
  localparam int PRE_W    = 8;

  typedef struct packed {
    logic       en;
    logic       periodic;
    logic       ie;
    logic       rsvd;
    logic [1:0] pre;
    logic       wide;
    logic       oneshot;
  } ctrl_t;

  typedef enum logic [2:0] {
    RS_CTRL   = 3'd0,
    RS_LOAD   = 3'd1,
    RS_VALUE  = 3'd2,
    RS_RAW    = 3'd3,
    RS_MASKED = 3'd4,
    RS_CLEAR  = 3'd5,
    RS_BGLOAD = 3'd6,
    RS_NONE   = 3'd7
  } reg_sel_e;

  function automatic logic [PRE_W-1:0] pre_limit(input logic [1:0] code);
    case (code)
      2'd1:    pre_limit = PRE_W'(15);
      2'd2:    pre_limit = PRE_W'(255);
      default: pre_limit = '0;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] width_mask(input logic wide);
    width_mask = wide ? {CNT_W{1'b1}} : CNT_W'({NARROW_W{1'b1}});
  endfunction

  function automatic logic [CNT_W-1:0] next_count(
    input logic [CNT_W-1:0] cur,
    input logic [CNT_W-1:0] rld,
    input logic             oneshot,
    input logic             periodic,
    input logic             wide
  );
    logic [CNT_W-1:0] m;
    m = width_mask(wide);
    if (cur != '0)     next_count = (cur - 1'b1) & m;
    else if (oneshot)  next_count = '0;
    else if (periodic) next_count = rld & m;
    else               next_count = m;
  endfunction

endpackage

// File: rtl/dtm_prescaler.sv
module dtm_prescaler
  import dtm_pkg::*;
#(
  parameter int PW = PRE_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       restart,
  input  logic       tick_en,
  input  logic [1:0] code,
  output logic       cnt_tick
);

  logic [PW-1:0] phase_q;
  logic [PW-1:0] limit;
  logic          at_limit;

  assign limit    = PW'(pre_limit(code));
  assign at_limit = (phase_q == limit);
  assign cnt_tick = en && tick_en && at_limit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              phase_q <= '0;
    else if (restart || !en) phase_q <= '0;
    else if (tick_en)        phase_q <= at_limit ? '0 : phase_q + 1'b1;
  end

  AST_NO_TICK_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !cnt_tick); // R9

  AST_TICK_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_tick |-> tick_en); // R9

endmodule

// File: rtl/dtm_counter.sv
module dtm_counter
  import dtm_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_tick,
  input  logic         load_wr,
  input  logic         bg_wr,
  input  logic [W-1:0] wdata,
  input  logic         oneshot,
  input  logic         periodic,
  input  logic         wide,
  output logic [W-1:0] count_val,
  output logic [W-1:0] reload_val,
  output logic         zero_evt
);

  logic [W-1:0] count_q;
  logic [W-1:0] direct_q;
  logic [W-1:0] reload_q;
  logic         pend_q;
  logic [W-1:0] mask;

  assign mask       = W'(width_mask(wide));
  assign count_val  = count_q & mask;
  assign reload_val = reload_q;
  assign zero_evt   = cnt_tick && !pend_q && (count_val == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      direct_q <= '0;
      reload_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      if (cnt_tick) begin
        if (pend_q) begin
          count_q <= direct_q & mask;
          pend_q  <= 1'b0;
        end else begin
          count_q <= W'(next_count(CNT_W'(count_val), CNT_W'(reload_q),
                                   oneshot, periodic, wide));
        end
      end
      if (load_wr) begin
        direct_q <= wdata;
        reload_q <= wdata;
        pend_q   <= 1'b1;
      end else if (bg_wr) begin
        reload_q <= wdata;
      end
    end
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_tick |=> $stable(count_q)); // R9

  AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && oneshot && !pend_q && count_val == '0) |=> count_q == '0); // R7

  AST_PEND_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && pend_q && !load_wr) |=> !pend_q); // R3

  AST_BG_KEEPS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (bg_wr && !load_wr && !cnt_tick) |=> $stable(count_q)); // R4

endmodule

// File: rtl/dtm_regs.sv
module dtm_regs
  import dtm_pkg::*;
#(
  parameter int AW = 5,
  parameter int W  = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          psel,
  input  logic          penable,
  input  logic          pwrite,
  input  logic [AW-1:0] paddr,
  input  logic [W-1:0]  pwdata,
  input  logic [W-1:0]  count_val,
  input  logic [W-1:0]  reload_val,
  input  logic          zero_evt,
  output ctrl_t         ctrl,
  output logic          ctrl_wr,
  output logic          load_wr,
  output logic          bg_wr,
  output logic          irq,
  output logic [W-1:0]  prdata
);

  localparam int CW = $bits(ctrl_t);

  ctrl_t    ctrl_q;
  logic     raw_q;
  logic     masked;
  logic     clr_wr;
  logic     wr;
  reg_sel_e sel;

  always_comb begin
    if (paddr[1:0] != 2'b00 || paddr[AW-1:2] > (AW-2)'(6)) sel = RS_NONE;
    else                                                     sel = reg_sel_e'(paddr[4:2]);
  end

  assign wr      = psel && penable && pwrite;
  assign ctrl_wr = wr && (sel == RS_CTRL);
  assign load_wr = wr && (sel == RS_LOAD);
  assign bg_wr   = wr && (sel == RS_BGLOAD);
  assign clr_wr  = wr && (sel == RS_CLEAR);

  assign ctrl   = ctrl_q;
  assign masked = raw_q && ctrl_q.ie;
  assign irq    = masked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      raw_q  <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        ctrl_q      <= ctrl_t'(pwdata[CW-1:0]);
        ctrl_q.rsvd <= 1'b0;
      end
      if (zero_evt)    raw_q <= 1'b1;
      else if (clr_wr) raw_q <= 1'b0;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (sel)
        RS_CTRL:   prdata = W'(ctrl_q);
        RS_LOAD:   prdata = reload_val;
        RS_VALUE:  prdata = count_val;
        RS_RAW:    prdata = W'(raw_q);
        RS_MASKED: prdata = W'(masked);
        default:   prdata = '0;
      endcase
    end
  end

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |=> raw_q); // R12

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && !zero_evt) |=> !raw_q); // R10

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.ie |-> !irq); // R11

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_wr |=> !ctrl_q.rsvd); // R2

endmodule

// File: rtl/dtm_timer.sv
module dtm_timer
  import dtm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              irq
);

  ctrl_t             ctrl;
  logic              ctrl_wr;
  logic              load_wr;
  logic              bg_wr;
  logic              cnt_tick;
  logic              zero_evt;
  logic [DATA_W-1:0] count_val;
  logic [DATA_W-1:0] reload_val;

  dtm_regs #(.AW(ADDR_W), .W(DATA_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .psel       (psel),
    .penable    (penable),
    .pwrite     (pwrite),
    .paddr      (paddr),
    .pwdata     (pwdata),
    .count_val  (count_val),
    .reload_val (reload_val),
    .zero_evt   (zero_evt),
    .ctrl       (ctrl),
    .ctrl_wr    (ctrl_wr),
    .load_wr    (load_wr),
    .bg_wr      (bg_wr),
    .irq        (irq),
    .prdata     (prdata)
  );

  dtm_prescaler #(.PW(PRE_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (ctrl.en),
    .restart  (ctrl_wr),
    .tick_en  (tick_en),
    .code     (ctrl.pre),
    .cnt_tick (cnt_tick)
  );

  dtm_counter #(.W(DATA_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .cnt_tick   (cnt_tick),
    .load_wr    (load_wr),
    .bg_wr      (bg_wr),
    .wdata      (pwdata),
    .oneshot    (ctrl.oneshot),
    .periodic   (ctrl.periodic),
    .wide       (ctrl.wide),
    .count_val  (count_val),
    .reload_val (reload_val),
    .zero_evt   (zero_evt)
  );

  AST_ZERO_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    zero_evt |-> (cnt_tick && ctrl.en)); // R10

endmodule

// File: tb/dtm_timer_tb.sv
module dtm_timer_tb;

  localparam logic [4:0] A_CTRL = 5'h00, A_LOAD = 5'h04, A_VAL = 5'h08,
                         A_RAW = 5'h0C, A_MSK = 5'h10, A_CLR = 5'h14,
                         A_BG = 5'h18, A_GAP = 5'h1C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [4:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  dtm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .psel(psel),
    .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
    .prdata(prdata), .irq(irq)
  );

  // {write, addr, data, expected read}
  localparam int NV = 11;
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, A_CTRL, 32'h0,      32'h0},       // R1
    {1'b1, A_CTRL, 32'hFF,     32'h0},
    {1'b0, A_CTRL, 32'h0,      32'hEF},      // R2 bit4 reads 0
    {1'b1, A_LOAD, 32'h1234,   32'h0},
    {1'b0, A_LOAD, 32'h0,      32'h1234},    // R3
    {1'b1, A_BG,   32'h55,     32'h0},
    {1'b0, A_LOAD, 32'h0,      32'h55},      // R4
    {1'b1, A_VAL,  32'hDEAD,   32'h0},
    {1'b0, A_VAL,  32'h0,      32'h0},       // R13
    {1'b0, A_GAP,  32'h0,      32'h0},       // R13
    {1'b1, A_CTRL, 32'h0,      32'h0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d, input bit tk = 1'b0);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; tick_en = tk;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0; tick_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, input logic [31:0] exp, input string req);
    @(negedge clk);
    psel = 1'b1; penable = 1'b1; pwrite = 1'b0; paddr = a;
    #1;
    chk(req, prdata, exp);
    psel = 1'b0; penable = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd(A_LOAD, 0, "R1"); rd(A_VAL, 0, "R1"); rd(A_RAW, 0, "R1"); rd(A_MSK, 0, "R1");
    chk("R1 irq", 32'(irq), 0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][69]) wr(VEC[i][68:64], VEC[i][63:32]);
      else            rd(VEC[i][68:64], VEC[i][31:0], "R2/R3/R4/R13 table");
    end

    // R6 periodic 32-bit, divide by 1, interrupt enabled
    wr(A_CTRL, 32'hE2);
    wr(A_LOAD, 3);
    ticks(1); rd(A_VAL, 3, "R3 load lands");
    ticks(2); rd(A_VAL, 1, "R6"); rd(A_RAW, 0, "R10 not yet");
    ticks(1); rd(A_VAL, 0, "R6"); rd(A_RAW, 1, "R10 set");
    rd(A_MSK, 1, "R11"); chk("R11 irq", 32'(irq), 1);
    ticks(1); rd(A_VAL, 3, "R6 reload");
    wr(A_RAW, 0); rd(A_RAW, 1, "R13 ro status");
    wr(A_CLR, 32'hABCD0000); rd(A_RAW, 0, "R10 clear"); chk("R11 irq low", 32'(irq), 0);

    // R4 background load leaves count running
    wr(A_BG, 7); ticks(1); rd(A_VAL, 2, "R4 count undisturbed");
    rd(A_LOAD, 7, "R4 readback");
    ticks(2); rd(A_VAL, 0, "R4"); ticks(1); rd(A_VAL, 7, "R4 reload bg");

    // R5 both written before the tick
    wr(A_LOAD, 10); wr(A_BG, 2); rd(A_LOAD, 2, "R5 readback");
    ticks(1); rd(A_VAL, 10, "R5 load value");
    ticks(10); rd(A_VAL, 0, "R5"); ticks(1); rd(A_VAL, 2, "R5 bg reload");
    wr(A_CLR, 0);

    // R7 one-shot (periodic also set: one-shot wins)
    wr(A_CTRL, 32'hC3); wr(A_LOAD, 2);
    ticks(1); rd(A_VAL, 2, "R7"); ticks(2); rd(A_VAL, 0, "R7");
    ticks(5); rd(A_VAL, 0, "R7 stays zero");
    wr(A_BG, 9); ticks(3); rd(A_VAL, 0, "R7 bg no restart");
    wr(A_LOAD, 4); ticks(1); rd(A_VAL, 4, "R7 restart");
    wr(A_CLR, 0);

    // R8 free-running wrap, 32 and 16 bit
    wr(A_CTRL, 32'h82); wr(A_LOAD, 1);
    ticks(2); rd(A_VAL, 0, "R8"); ticks(1); rd(A_VAL, 32'hFFFFFFFF, "R8 wrap32");
    wr(A_CTRL, 32'h80); wr(A_LOAD, 32'h12345);
    ticks(1); rd(A_VAL, 32'h2345, "R8 narrow load");
    wr(A_LOAD, 0); ticks(2); rd(A_VAL, 32'hFFFF, "R8 wrap16");
    rd(A_RAW, 1, "R10 set on way down");
    wr(A_CLR, 0);

    // R9 prescale
    wr(A_CTRL, 32'h86); wr(A_LOAD, 100);
    ticks(16); rd(A_VAL, 100, "R9 div16 load");
    ticks(15); rd(A_VAL, 100, "R9 div16 hold");
    ticks(1);  rd(A_VAL, 99, "R9 div16 step");
    wr(A_CTRL, 32'h8A); wr(A_LOAD, 50);
    ticks(256); rd(A_VAL, 50, "R9 div256 load");
    ticks(255); rd(A_VAL, 50, "R9 div256 hold");
    ticks(1);   rd(A_VAL, 49, "R9 div256 step");
    wr(A_CTRL, 32'h8E); ticks(1); rd(A_VAL, 48, "R9 code3 div1");
    wr(A_CTRL, 32'h0E); ticks(20); rd(A_VAL, 48, "R9 disabled");

    // R12 set wins over clear; R11 masked with ie off
    wr(A_CTRL, 32'hC2); wr(A_LOAD, 2);
    ticks(3); rd(A_VAL, 0, "R12 setup"); rd(A_RAW, 1, "R10");
    rd(A_MSK, 0, "R11 masked off"); chk("R11 irq off", 32'(irq), 0);
    ticks(2); rd(A_VAL, 1, "R12 setup");
    wr(A_CLR, 0, 1'b1);
    rd(A_VAL, 0, "R12 zero hit"); rd(A_RAW, 1, "R12 set wins");
    wr(A_CLR, 0); rd(A_RAW, 0, "R10 clear after");
    rd(A_CLR, 0, "R13 clear reads 0");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule